// File: doc/BRIEF.md
# Serial Loopback and Echo Router

This block sits between a serial transmitter, a serial receiver and the transmit and receive data pins. Two mode bits steer the data. In local loopback the transmitter's serial data is fed back into the receiver and still drives the transmit pin. In auto echo the receive pin is copied straight to the transmit pin, the receiver keeps listening to the receive pin, and the transmitter's data goes nowhere. When neither bit is set, the transmitter drives the pin and the receiver takes the pin.

The block also gates the two modem-control enables. When auto enables is configured, clear-to-send (active low) qualifies the transmitter and carrier-detect (active low) qualifies the receiver. Local loopback removes both of these gates. Auto echo removes only the clear-to-send gate. Change-of-state detection on both modem pins is separate from this gating, so it reports every transition in every mode. The three pins from outside the chip pass through a synchronizer. All outputs are registered. Both mode bits are loaded through a write strobe and are cleared by either the hardware reset or the channel reset.

Top module: `serlb_router`

## Requirements
- R1: While `rst_i` is high, and in the first cycle after it, `txd_o`=1, `rx_data_o`=1, `tx_en_o`=0, `rx_en_o`=0, `cts_chg_o`=0, `dcd_chg_o`=0. The hardware reset also clears both mode bits.
- R2: With neither mode bit set, `txd_o` equals `tx_data_i` one clock later. `rx_data_o` equals `rxd_i` SYNC_STAGES+1 clocks later.
- R3: With `loop`=1 and `echo`=0, `rx_data_o` follows `tx_data_i` and `txd_o` also follows `tx_data_i`.
- R4: With `loop`=1, `tx_en_o`=`tx_req_i` and `rx_en_o`=`rx_req_i`, whatever the values of `cts_n_i`, `dcd_n_i` and `auto_en_i`.
- R5: With `echo`=1 and `loop`=0, `txd_o` follows the synchronized `rxd_i`, `rx_data_o` follows `rxd_i`, and `tx_data_i` appears on no output.
- R6: With `echo`=1 and `loop`=0, `tx_en_o`=`tx_req_i` regardless of `cts_n_i`. When `auto_en_i`=1, `rx_en_o` is still `rx_req_i & ~dcd_n_i`.
- R7: With both bits set, `txd_o` follows `rxd_i` and `rx_data_o` follows `tx_data_i`.
- R8: With neither bit set and `auto_en_i`=0, the enables equal the requests. With `auto_en_i`=1, `tx_en_o`=`tx_req_i & ~cts_n_i` and `rx_en_o`=`rx_req_i & ~dcd_n_i`.
- R9: Each transition of `cts_n_i` (or `dcd_n_i`) produces exactly one single-cycle pulse on `cts_chg_o` (or `dcd_chg_o`), in every mode.
- R10: A one-cycle `chan_rst_i` clears both mode bits. Routing then returns to the normal paths.
- R11: The mode bits load from `cfg_loop_i`/`cfg_echo_i` only when `cfg_wr_i`=1 and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous hardware reset, active high |
| chan_rst_i | input | 1 | Channel reset: clears the mode bits |
| cfg_wr_i | input | 1 | Mode write strobe |
| cfg_loop_i | input | 1 | Local loopback value to load |
| cfg_echo_i | input | 1 | Auto echo value to load |
| auto_en_i | input | 1 | Auto enables configuration |
| tx_data_i | input | 1 | Serial data from the transmitter |
| tx_req_i | input | 1 | Transmitter enable request |
| rx_req_i | input | 1 | Receiver enable request |
| rxd_i | input | 1 | Receive data pin (asynchronous) |
| cts_n_i | input | 1 | Clear-to-send pin, active low (asynchronous) |
| dcd_n_i | input | 1 | Carrier-detect pin, active low (asynchronous) |
| txd_o | output | 1 | Transmit data pin |
| rx_data_o | output | 1 | Serial data to the receiver |
| tx_en_o | output | 1 | Effective transmit enable |
| rx_en_o | output | 1 | Effective receive enable |
| cts_chg_o | output | 1 | Clear-to-send change pulse |
| dcd_chg_o | output | 1 | Carrier-detect change pulse |

## Verification
The assertions assume that `tx_data_i`, `tx_req_i`, `rx_req_i`, `auto_en_i` and the configuration inputs are synchronous to `clk_i`. They relate each registered output to the mode bits and inputs of the cycle before. The pins may change at any time, because the properties only look at their synchronized copies. The stimulus changes every input on the falling clock edge. After each mode or pin change it waits several cycles before sampling, and it holds every pin high through reset. As a result, the synchronizer's reset value matches the pins and no change pulse is produced at start-up.

// File: rtl/serlb_pkg.sv
package serlb_pkg;
  typedef struct packed {
    logic echo;
    logic loop;
  } serlb_mode_t;

  localparam serlb_mode_t MODE_NONE = '{echo: 1'b0, loop: 1'b0};
endpackage

// File: rtl/serlb_sync.sv
module serlb_sync #(
  parameter int WIDTH     = 3,
  parameter int STAGES    = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) stage_q[0] <= RST_VAL;
    else       stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i) begin
      if (rst_i) stage_q[s] <= RST_VAL;
      else       stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/serlb_mode_reg.sv
module serlb_mode_reg
  import serlb_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        chan_rst_i,
  input  logic        wr_i,
  input  logic        loop_i,
  input  logic        echo_i,
  output serlb_mode_t mode_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i || chan_rst_i) mode_o <= MODE_NONE;
    else if (wr_i)           mode_o <= '{echo: echo_i, loop: loop_i};
  end
endmodule

// File: rtl/serlb_edge.sv
module serlb_edge #(
  parameter int WIDTH = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] chg_o
);
  logic [WIDTH-1:0] prev_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        prev_q[b] <= RST_VAL[b];
        chg_o[b]  <= 1'b0;
      end else begin
        prev_q[b] <= lvl_i[b];
        chg_o[b]  <= lvl_i[b] ^ prev_q[b];
      end
    end
  end
endmodule

// File: rtl/serlb_route.sv
module serlb_route
  import serlb_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_i,
  input  serlb_mode_t mode_i,
  input  logic        auto_en_i,
  input  logic        tx_data_i,
  input  logic        tx_req_i,
  input  logic        rx_req_i,
  input  logic        rxd_s_i,
  input  logic        cts_n_s_i,
  input  logic        dcd_n_s_i,
  output logic        txd_o,
  output logic        rx_data_o,
  output logic        tx_en_o,
  output logic        rx_en_o
);
  logic txd_d, rxdat_d, cts_ok, dcd_ok;

  always_comb begin
    // echo owns the pin, loopback owns the receiver input
    txd_d   = mode_i.echo ? rxd_s_i   : tx_data_i;
    rxdat_d = mode_i.loop ? tx_data_i : rxd_s_i;
    cts_ok  = !auto_en_i || !cts_n_s_i || mode_i.loop || mode_i.echo;
    dcd_ok  = !auto_en_i || !dcd_n_s_i || mode_i.loop;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      txd_o     <= 1'b1;
      rx_data_o <= 1'b1;
      tx_en_o   <= 1'b0;
      rx_en_o   <= 1'b0;
    end else begin
      txd_o     <= txd_d;
      rx_data_o <= rxdat_d;
      tx_en_o   <= tx_req_i && cts_ok;
      rx_en_o   <= rx_req_i && dcd_ok;
    end
  end
endmodule

// File: rtl/serlb_router.sv
module serlb_router
  import serlb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic chan_rst_i,
  input  logic cfg_wr_i,
  input  logic cfg_loop_i,
  input  logic cfg_echo_i,
  input  logic auto_en_i,
  input  logic tx_data_i,
  input  logic tx_req_i,
  input  logic rx_req_i,
  input  logic rxd_i,
  input  logic cts_n_i,
  input  logic dcd_n_i,
  output logic txd_o,
  output logic rx_data_o,
  output logic tx_en_o,
  output logic rx_en_o,
  output logic cts_chg_o,
  output logic dcd_chg_o
);
  localparam int PINS = 3;

  serlb_mode_t     mode_q;
  logic [PINS-1:0] pin_s;
  logic [1:0]      chg;

  serlb_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk_i(clk_i), .rst_i(rst_i),
    .d_i  ({dcd_n_i, cts_n_i, rxd_i}),
    .q_o  (pin_s)
  );

  serlb_mode_reg u_mode (
    .clk_i(clk_i), .rst_i(rst_i), .chan_rst_i(chan_rst_i),
    .wr_i(cfg_wr_i), .loop_i(cfg_loop_i), .echo_i(cfg_echo_i),
    .mode_o(mode_q)
  );

  serlb_edge #(.WIDTH(2), .RST_VAL('1)) u_edge (
    .clk_i(clk_i), .rst_i(rst_i),
    .lvl_i(pin_s[2:1]),
    .chg_o(chg)
  );

  serlb_route u_route (
    .clk_i(clk_i), .rst_i(rst_i), .mode_i(mode_q),
    .auto_en_i(auto_en_i), .tx_data_i(tx_data_i),
    .tx_req_i(tx_req_i), .rx_req_i(rx_req_i),
    .rxd_s_i(pin_s[0]), .cts_n_s_i(pin_s[1]), .dcd_n_s_i(pin_s[2]),
    .txd_o(txd_o), .rx_data_o(rx_data_o),
    .tx_en_o(tx_en_o), .rx_en_o(rx_en_o)
  );

  assign cts_chg_o = chg[0];
  assign dcd_chg_o = chg[1];
endmodule

// File: rtl/serlb_router_chk.sv
module serlb_router_chk (
  input logic clk_i,
  input logic rst_i,
  input logic chan_rst_i,
  input logic m_loop,
  input logic m_echo,
  input logic tx_data_i,
  input logic tx_req_i,
  input logic rxd_s,
  input logic txd_o,
  input logic rx_data_o,
  input logic tx_en_o,
  input logic cts_chg_o,
  input logic dcd_chg_o
);
  p_rst_idle_r1: assert property (@(posedge clk_i)
    rst_i |=> (txd_o && rx_data_o && !tx_en_o && !cts_chg_o && !dcd_chg_o && !m_loop && !m_echo));

  p_loop_rx_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    m_loop |=> rx_data_o == $past(tx_data_i));

  p_loop_txen_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (m_loop && tx_req_i) |=> tx_en_o);

  p_echo_txd_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    m_echo |=> txd_o == $past(rxd_s));

  p_echo_txen_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (m_echo && tx_req_i) |=> tx_en_o);

  p_cts_pulse_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    cts_chg_o |=> !cts_chg_o);

  p_dcd_pulse_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    dcd_chg_o |=> !dcd_chg_o);

  p_chan_clear_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    chan_rst_i |=> (!m_loop && !m_echo));
endmodule

bind serlb_router serlb_router_chk u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .chan_rst_i(chan_rst_i),
  .m_loop(mode_q.loop), .m_echo(mode_q.echo),
  .tx_data_i(tx_data_i), .tx_req_i(tx_req_i), .rxd_s(pin_s[0]),
  .txd_o(txd_o), .rx_data_o(rx_data_o), .tx_en_o(tx_en_o),
  .cts_chg_o(cts_chg_o), .dcd_chg_o(dcd_chg_o)
);

// File: tb/serlb_router_tb.sv
module serlb_router_tb;
  logic clk = 1'b0;
  logic rst, chan_rst, cfg_wr, cfg_loop, cfg_echo, auto_en;
  logic tx_data, tx_req, rx_req, rxd, cts_n, dcd_n;
  logic txd, rx_data, tx_en, rx_en, cts_chg, dcd_chg;
  int n_run = 0, n_fail = 0;
  int cts_pulses = 0, dcd_pulses = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  serlb_router u_dut (
    .clk_i(clk), .rst_i(rst), .chan_rst_i(chan_rst), .cfg_wr_i(cfg_wr),
    .cfg_loop_i(cfg_loop), .cfg_echo_i(cfg_echo), .auto_en_i(auto_en),
    .tx_data_i(tx_data), .tx_req_i(tx_req), .rx_req_i(rx_req),
    .rxd_i(rxd), .cts_n_i(cts_n), .dcd_n_i(dcd_n),
    .txd_o(txd), .rx_data_o(rx_data), .tx_en_o(tx_en), .rx_en_o(rx_en),
    .cts_chg_o(cts_chg), .dcd_chg_o(dcd_chg)
  );

  always @(negedge clk) begin
    cts_pulses <= cts_pulses + int'(cts_chg);
    dcd_pulses <= dcd_pulses + int'(dcd_chg);
  end

  // {loop,echo,auto,cts_n,dcd_n,tx_data,rxd,tx_req,rx_req, exp txd,rx_data,tx_en,rx_en}
  localparam int NV = 12;
  localparam logic [12:0] VEC [NV] = '{
    13'b000_11_10_11_1011, // R2 R8 normal, auto off
    13'b000_11_01_10_0110, // R2 R8
    13'b001_11_10_11_1000, // R8 auto, pins deasserted
    13'b001_00_01_11_0111, // R8 auto, pins asserted
    13'b001_01_11_11_1110, // R8 auto, carrier missing
    13'b101_11_01_11_0011, // R3 R4 loopback
    13'b101_11_10_11_1111, // R3 R4
    13'b101_00_10_00_1100, // R4 requests low
    13'b011_11_10_11_0010, // R5 R6 echo, carrier missing
    13'b011_10_01_11_1111, // R5 R6 echo, carrier present
    13'b111_11_10_11_0111, // R7 both
    13'b111_11_01_11_1011  // R7 both
  };

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string req, input string what);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_mode(input logic lp, input logic ec);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_loop = lp; cfg_echo = ec;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_loop = 1'b0; cfg_echo = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; chan_rst = 1'b0; cfg_wr = 1'b0; cfg_loop = 1'b0; cfg_echo = 1'b0;
    auto_en = 1'b0; tx_data = 1'b0; tx_req = 1'b1; rx_req = 1'b1;
    rxd = 1'b1; cts_n = 1'b1; dcd_n = 1'b1;
    wait_n(3);
    // R1 reset state
    chk(txd, 1'b1, "R1", "txd in reset");
    chk(rx_data, 1'b1, "R1", "rx_data in reset");
    chk(tx_en, 1'b0, "R1", "tx_en in reset");
    chk(rx_en, 1'b0, "R1", "rx_en in reset");
    chk(cts_chg | dcd_chg, 1'b0, "R1", "change pulses in reset");
    rst = 1'b0;
    wait_n(4);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic [12:0] e;
      string tag;
      e = VEC[v];
      tag = (v < 5) ? "R2/R8" : (v < 8) ? "R3/R4" : (v < 10) ? "R5/R6" : "R7";
      set_mode(e[12], e[11]);
      auto_en = e[10]; cts_n = e[9]; dcd_n = e[8];
      tx_data = e[7]; rxd = e[6]; tx_req = e[5]; rx_req = e[4];
      wait_n(6);
      chk(txd, e[3], tag, $sformatf("vec %0d txd", v));
      chk(rx_data, e[2], tag, $sformatf("vec %0d rx_data", v));
      chk(tx_en, e[1], tag, $sformatf("vec %0d tx_en", v));
      chk(rx_en, e[0], tag, $sformatf("vec %0d rx_en", v));
    end

    // R2 latency in normal mode
    set_mode(1'b0, 1'b0);
    auto_en = 1'b0; cts_n = 1'b1; dcd_n = 1'b1; tx_data = 1'b0; rxd = 1'b0;
    wait_n(6);
    tx_data = 1'b1; rxd = 1'b1;
    wait_n(1);
    chk(txd, 1'b1, "R2", "txd one clock after tx_data");
    wait_n(1);
    chk(rx_data, 1'b0, "R2", "rx_data still old after two clocks");
    wait_n(1);
    chk(rx_data, 1'b1, "R2", "rx_data after three clocks");

    // R5 tx_data invisible in echo
    set_mode(1'b0, 1'b1);
    rxd = 1'b1; tx_data = 1'b0;
    wait_n(6);
    chk(txd, 1'b1, "R5", "txd ignores tx_data in echo");
    chk(rx_data, 1'b1, "R5", "rx_data ignores tx_data in echo");

    // R11 mode holds without a write strobe
    set_mode(1'b1, 1'b0);
    cfg_loop = 1'b0; cfg_echo = 1'b1;
    tx_data = 1'b0; rxd = 1'b1;
    wait_n(6);
    chk(rx_data, 1'b0, "R11", "loopback held without strobe");
    chk(txd, 1'b0, "R11", "echo not loaded without strobe");
    cfg_echo = 1'b0;

    // R9 change pulses in loopback with auto enables
    auto_en = 1'b1;
    wait_n(2);
    cts_pulses = 0; dcd_pulses = 0;
    cts_n = 1'b0;
    wait_n(8);
    chk_int(cts_pulses, 1, "R9", "cts pulses in loopback");
    chk_int(dcd_pulses, 0, "R9", "dcd pulses with dcd steady");
    dcd_n = 1'b0; cts_n = 1'b1;
    wait_n(8);
    chk_int(cts_pulses, 2, "R9", "cts pulses after second edge");
    chk_int(dcd_pulses, 1, "R9", "dcd pulses in loopback");

    // R10 channel reset clears mode
    @(negedge clk); chan_rst = 1'b1;
    @(negedge clk); chan_rst = 1'b0;
    tx_data = 1'b0; rxd = 1'b1; cts_n = 1'b1; dcd_n = 1'b1; auto_en = 1'b1;
    wait_n(6);
    chk(rx_data, 1'b1, "R10", "rx_data from pin after channel reset");
    chk(tx_en, 1'b0, "R10", "cts gating restored after channel reset");
    chk(txd, 1'b0, "R10", "txd from tx_data after channel reset");

    // R9 in normal mode
    cts_pulses = 0; dcd_pulses = 0;
    dcd_n = 1'b0;
    wait_n(8);
    chk_int(dcd_pulses, 1, "R9", "dcd pulses in normal mode");

    // R1 hardware reset clears mode
    set_mode(1'b1, 1'b1);
    dcd_n = 1'b1;
    wait_n(6);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk(txd, 1'b1, "R1", "txd after mid-run reset");
    chk(rx_en, 1'b0, "R1", "rx_en after mid-run reset");
    rst = 1'b0;
    tx_data = 1'b1; rxd = 1'b0; auto_en = 1'b0;
    wait_n(6);
    chk(rx_data, 1'b0, "R1", "loopback cleared by hardware reset");
    chk(txd, 1'b1, "R1", "echo cleared by hardware reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule